// File: doc/BRIEF.md
# Data Read Access Sequencer

This block handles one data read at a time on its way through a memory management path. It works through the steps in a fixed order. First it checks whether translation is switched off, which sends the read straight to memory. Then it checks the size code and alignment. Next it asks for a translation of the word-aligned address and for a permission verdict. Finally it probes three data stores in turn: the read buffer, the main data cache and the mini data cache. When all three miss, the page attribute bits and the physical address decide what happens next. The choices are:

- a soft flush of one cache, for a reserved physical window;
- a full write-buffer drain;
- a line allocation in the main or mini cache;
- a plain uncached memory read.

All collaborators (translation, permission, buffers, caches, memory) sit behind one shared request/acknowledge port. The block names the operation it wants on that port and waits for the reply. The result, either a data word or a fault code, is returned with a one-cycle completion pulse.

The state machine moves through these states:

- **IDLE**: accepts a request.
- **BYPASS**: untranslated memory read.
- **XLATE**: translation.
- **PERM**: permission check.
- **LK_RB**, **LK_MAIN**, **LK_MINI**: the three lookups.
- **FLUSH**, **DRAIN**, **ALLOC**, **MEM**: the miss actions.
- **DONE**: completion pulse.

Its transitions are:

- IDLE→DONE for a bad size or misalignment.
- IDLE→BYPASS when translation is off, and IDLE→XLATE otherwise.
- XLATE→DONE on a translation fault, and XLATE→PERM otherwise.
- PERM→DONE on a permission fault, and PERM→LK_RB otherwise.
- From each lookup state: a hit goes to DONE, and a miss goes to the next lookup. After the last lookup a miss goes to FLUSH, DONE, DRAIN, ALLOC or MEM.
- DRAIN→ALLOC or DRAIN→MEM.
- BYPASS, FLUSH, ALLOC and MEM each go to DONE on acknowledge.
- DONE→IDLE.

Top module: `dread_seq`

## Requirements
- R1: Size codes are 0 for byte, 1 for halfword and 2 for word. Code 3 completes with fault code 4 and issues no sub-operation. Fault codes are: 0 none, 1 alignment, 2 translation, 3 permission, 4 size error.
- R2: With `cfg_mmu_en` low, the block issues exactly one memory read (op kind 10) at the unmodified request address with the request size. No alignment check or translation is done, and the returned word is passed through.
- R3: With `cfg_align_en` high and translation on, a word read with address bits [1:0] nonzero, or a halfword read with bit 0 set, completes with fault 1 and issues no sub-operation. With `cfg_align_en` low, such reads proceed to translation.
- R4: Translation (op kind 0) is requested at the request address with bits [1:0] cleared. A translation fault completes with code 2. A permission fault (op kind 1) completes with code 3. Neither issues any further operation.
- R5: Lookups are issued in the order read buffer (kind 2), main cache (kind 3), mini cache (kind 4). The first hit returns its word and ends the read with no later lookup.
- R6: After three misses, a physical address in [0xE0000000, 0xE8000000) causes no memory access. With C=1 it flushes the main cache (kind 5) if B=1, or the mini cache (kind 6) if B=0. With C=0 it does nothing. Either way the read completes with data 0 and no fault. Addresses 0xE8000000 and 0xDFFFFFFC are outside the window.
- R7: Outside the window with B=1, a write-buffer drain (kind 7) is issued and acknowledged before any allocate or memory read.
- R8: Outside the window with C=1 and `cfg_dcache_en` high, a line is allocated in the main cache (kind 8) if B=1, or the mini cache (kind 9) if B=0. The word returned by the allocate is the result.
- R9: Otherwise the read is an uncached memory read (kind 10). Its address is the physical address ORed with request address bits [1:0] for a byte, with bit 1 for a halfword, and with nothing for a word.
- R10: `req_ready` is high only when no read is in progress. `done` is a single-cycle pulse. A sub-operation request keeps its kind and address stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | High while idle, request accepted |
| req_addr | input | 32 | Virtual read address |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word) |
| cfg_mmu_en | input | 1 | Translation enabled |
| cfg_align_en | input | 1 | Alignment checking enabled |
| cfg_dcache_en | input | 1 | Data cache enabled |
| op_req | output | 1 | Sub-operation request |
| op_kind | output | 4 | Sub-operation code (0..10, see requirements) |
| op_addr | output | 32 | Sub-operation address |
| op_size | output | 2 | Request size code forwarded |
| op_ack | input | 1 | Sub-operation acknowledge |
| op_fault | input | 1 | Translation or permission fault with acknowledge |
| op_hit | input | 1 | Lookup hit with acknowledge |
| op_b | input | 1 | Page B attribute with translation acknowledge |
| op_c | input | 1 | Page C attribute with translation acknowledge |
| op_rdata | input | 32 | Physical address (translation) or data word |
| done | output | 1 | Completion pulse |
| rsp_data | output | 32 | Returned data word |
| rsp_fault | output | 3 | Returned fault code |

## Verification
The embedded assertions watch four things on every cycle:

- the completion pulse width;
- that a sub-operation stays stable while it waits for acknowledge;
- that no sub-operation is issued while the block is ready;
- that translation addresses are word-aligned, flushes occur only with C=1, and every allocate or translated memory read with B=1 comes after an acknowledged drain.

Only the bench scenarios show the deeper behaviour. These include which operations a read touches and in what lookup order, the fault code chosen, the exact edges of the flush window, and the low-bit merging of uncached addresses. The bench checks each of these by the data word it expects and by the set of operation kinds it expects to see.

// File: rtl/dread_pkg.sv
package dread_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        F_NONE  = 3'd0,
        F_ALIGN = 3'd1,
        F_XLATE = 3'd2,
        F_PERM  = 3'd3,
        F_SIZE  = 3'd4
    } fault_e;

    typedef enum logic [3:0] {
        OP_XLATE      = 4'd0,
        OP_PERM       = 4'd1,
        OP_LK_RB      = 4'd2,
        OP_LK_MAIN    = 4'd3,
        OP_LK_MINI    = 4'd4,
        OP_FLUSH_MAIN = 4'd5,
        OP_FLUSH_MINI = 4'd6,
        OP_DRAIN      = 4'd7,
        OP_ALLOC_MAIN = 4'd8,
        OP_ALLOC_MINI = 4'd9,
        OP_MEM        = 4'd10
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BYPASS,
        S_XLATE,
        S_PERM,
        S_LK_RB,
        S_LK_MAIN,
        S_LK_MINI,
        S_FLUSH,
        S_DRAIN,
        S_ALLOC,
        S_MEM,
        S_DONE
    } state_e;

endpackage

// File: rtl/dread_align_chk.sv
module dread_align_chk
    import dread_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    input  logic       align_en,
    output logic       size_bad,
    output logic       misaligned
);

    always_comb begin
        size_bad   = (size == SZ_BAD);
        misaligned = 1'b0;
        if (align_en) begin
            unique case (size)
                SZ_WORD: misaligned = (addr_lo != 2'b00);
                SZ_HALF: misaligned = addr_lo[0];
                default: misaligned = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dread_addr_map.sv
module dread_addr_map
    import dread_pkg::*;
#(
    parameter int unsigned    AW     = 32,
    parameter logic [AW-1:0]  WIN_LO = 32'hE000_0000,
    parameter logic [AW-1:0]  WIN_HI = 32'hE800_0000
) (
    input  logic [AW-1:0] pa,
    input  logic [1:0]    va_lo,
    input  logic [1:0]    size,
    output logic          in_win,
    output logic [AW-1:0] unc_addr
);

    localparam int unsigned HI_W = AW - 2;

    always_comb begin
        in_win = (pa >= WIN_LO) && (pa < WIN_HI);
        unique case (size)
            SZ_BYTE: unc_addr = pa | {{HI_W{1'b0}}, va_lo};
            SZ_HALF: unc_addr = pa | {{HI_W{1'b0}}, va_lo[1], 1'b0};
            default: unc_addr = pa;
        endcase
    end

endmodule

// File: rtl/dread_seq.sv
module dread_seq
    import dread_pkg::*;
#(
    parameter int unsigned   AW     = 32,
    parameter int unsigned   DW     = 32,
    parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
    parameter logic [AW-1:0] WIN_HI = 32'hE800_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          cfg_mmu_en,
    input  logic          cfg_align_en,
    input  logic          cfg_dcache_en,
    output logic          op_req,
    output logic [3:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [1:0]    op_size,
    input  logic          op_ack,
    input  logic          op_fault,
    input  logic          op_hit,
    input  logic          op_b,
    input  logic          op_c,
    input  logic [DW-1:0] op_rdata,
    output logic          done,
    output logic [DW-1:0] rsp_data,
    output logic [2:0]    rsp_fault
);

    localparam logic [AW-1:0] WORD_MASK = ~{{(AW-2){1'b0}}, 2'b11};

    state_e        state_q, state_d;
    logic [AW-1:0] va_q, pa_q, va_w, unc_addr;
    logic [1:0]    size_q;
    logic          b_q, c_q, in_win;
    logic          size_bad, misaligned, accept;
    logic          rsp_ld, drained_q;
    logic [DW-1:0] rsp_data_n;
    fault_e        rsp_fault_n;

    assign accept = req_valid && req_ready;
    assign va_w   = va_q & WORD_MASK;

    dread_align_chk u_align (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .align_en   (cfg_align_en),
        .size_bad   (size_bad),
        .misaligned (misaligned)
    );

    dread_addr_map #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_map (
        .pa       (pa_q),
        .va_lo    (va_q[1:0]),
        .size     (size_q),
        .in_win   (in_win),
        .unc_addr (unc_addr)
    );

    // next state and response loading
    always_comb begin
        state_d     = state_q;
        rsp_ld      = 1'b0;
        rsp_data_n  = '0;
        rsp_fault_n = F_NONE;
        unique case (state_q)
            S_IDLE: if (accept) begin
                if (size_bad) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_fault_n = F_SIZE;
                end else if (!cfg_mmu_en) begin
                    state_d = S_BYPASS;
                end else if (misaligned) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_fault_n = F_ALIGN;
                end else begin
                    state_d = S_XLATE;
                end
            end
            S_XLATE: if (op_ack) begin
                if (op_fault) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_fault_n = F_XLATE;
                end else begin
                    state_d = S_PERM;
                end
            end
            S_PERM: if (op_ack) begin
                if (op_fault) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_fault_n = F_PERM;
                end else begin
                    state_d = S_LK_RB;
                end
            end
            S_LK_RB, S_LK_MAIN: if (op_ack) begin
                if (op_hit) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_data_n = op_rdata;
                end else begin
                    state_d = (state_q == S_LK_RB) ? S_LK_MAIN : S_LK_MINI;
                end
            end
            S_LK_MINI: if (op_ack) begin
                if (op_hit) begin
                    state_d = S_DONE; rsp_ld = 1'b1; rsp_data_n = op_rdata;
                end else if (in_win) begin
                    if (c_q) begin
                        state_d = S_FLUSH;
                    end else begin
                        state_d = S_DONE; rsp_ld = 1'b1;
                    end
                end else if (b_q) begin
                    state_d = S_DRAIN;
                end else if (c_q && cfg_dcache_en) begin
                    state_d = S_ALLOC;
                end else begin
                    state_d = S_MEM;
                end
            end
            S_DRAIN: if (op_ack) begin
                state_d = (c_q && cfg_dcache_en) ? S_ALLOC : S_MEM;
            end
            S_FLUSH: if (op_ack) begin
                state_d = S_DONE; rsp_ld = 1'b1;
            end
            S_BYPASS, S_ALLOC, S_MEM: if (op_ack) begin
                state_d = S_DONE; rsp_ld = 1'b1; rsp_data_n = op_rdata;
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request, translation and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q      <= '0;
            size_q    <= SZ_BYTE;
            pa_q      <= '0;
            b_q       <= 1'b0;
            c_q       <= 1'b0;
            rsp_data  <= '0;
            rsp_fault <= F_NONE;
            drained_q <= 1'b0;
        end else begin
            if (accept) begin
                va_q      <= req_addr;
                size_q    <= req_size;
                drained_q <= 1'b0;
            end
            if (state_q == S_XLATE && op_ack) begin
                pa_q <= op_rdata[AW-1:0];
                b_q  <= op_b;
                c_q  <= op_c;
            end
            if (state_q == S_DRAIN && op_ack) drained_q <= 1'b1;
            if (rsp_ld) begin
                rsp_data  <= rsp_data_n;
                rsp_fault <= rsp_fault_n;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        done      = (state_q == S_DONE);
        op_req    = 1'b1;
        op_kind   = OP_MEM;
        op_addr   = va_w;
        op_size   = size_q;
        unique case (state_q)
            S_BYPASS:  begin op_kind = OP_MEM;     op_addr = va_q;  end
            S_XLATE:   op_kind = OP_XLATE;
            S_PERM:    op_kind = OP_PERM;
            S_LK_RB:   op_kind = OP_LK_RB;
            S_LK_MAIN: op_kind = OP_LK_MAIN;
            S_LK_MINI: op_kind = OP_LK_MINI;
            S_FLUSH:   begin
                op_kind = b_q ? OP_FLUSH_MAIN : OP_FLUSH_MINI;
                op_addr = pa_q;
            end
            S_DRAIN:   begin op_kind = OP_DRAIN;   op_addr = pa_q;  end
            S_ALLOC:   begin
                op_kind = b_q ? OP_ALLOC_MAIN : OP_ALLOC_MINI;
                op_addr = pa_q;
            end
            S_MEM:     begin op_kind = OP_MEM;     op_addr = unc_addr; end
            default:   op_req = 1'b0;
        endcase
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> (op_req && $stable(op_kind) && $stable(op_addr)));

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |-> !req_ready);

    // R4
    xlate_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_kind == OP_XLATE) |-> (op_addr[1:0] == 2'b00));

    // R6
    flush_needs_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && (op_kind == OP_FLUSH_MAIN || op_kind == OP_FLUSH_MINI)) |-> c_q);

    // R7
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && b_q && state_q != S_BYPASS &&
         (op_kind == OP_ALLOC_MAIN || op_kind == OP_ALLOC_MINI || op_kind == OP_MEM))
        |-> drained_q);

endmodule

// File: tb/dread_seq_tb_top.sv
`timescale 1ns/1ps
module dread_seq_tb_top;
    import dread_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        cfg_mmu_en = 1'b0, cfg_align_en = 1'b1, cfg_dcache_en = 1'b1;
    logic        op_req;
    logic [3:0]  op_kind;
    logic [31:0] op_addr;
    logic [1:0]  op_size;
    logic        op_ack = 1'b0, op_fault = 1'b0, op_hit = 1'b0, op_b = 1'b0, op_c = 1'b0;
    logic [31:0] op_rdata = '0;
    logic        done;
    logic [31:0] rsp_data;
    logic [2:0]  rsp_fault;

    always #10 clk = ~clk;

    dread_seq dut_i (.*);

    typedef struct {
        logic [31:0] data;
        logic [2:0]  fault;
        logic [15:0] mask;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        cur;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] sc_pa = '0;
    logic        sc_xf = 0, sc_pf = 0, sc_b = 0, sc_c = 0;
    logic [2:0]  sc_hit = '0;
    logic [15:0] seen = '0;
    bit          order_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // responder and scoreboard monitor
    always @(negedge clk) begin
        if (done) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected done", 32'd1, 32'd0);
            end else begin
                cur = exp_q.pop_front();
                chk({cur.tag, " data"},  rsp_data, cur.data);
                chk({cur.tag, " fault"}, {29'd0, rsp_fault}, {29'd0, cur.fault});
                chk({cur.tag, " ops"},   {16'd0, seen}, {16'd0, cur.mask});
                chk({cur.tag, " order R5 R7"}, {31'd0, order_err}, 32'd0);
            end
            seen      = '0;
            order_err = 0;
        end
        if (op_req && !op_ack) begin
            op_ack   = 1'b1;
            op_fault = 1'b0;
            op_hit   = 1'b0;
            op_rdata = op_addr ^ {op_kind, 28'd0};
            case (op_kind)
                OP_XLATE: begin
                    op_rdata = sc_pa; op_fault = sc_xf; op_b = sc_b; op_c = sc_c;
                end
                OP_PERM:    op_fault = sc_pf;
                OP_LK_RB:   op_hit = sc_hit[0];
                OP_LK_MAIN: begin op_hit = sc_hit[1]; if (!seen[OP_LK_RB]) order_err = 1; end
                OP_LK_MINI: begin op_hit = sc_hit[2]; if (!seen[OP_LK_MAIN]) order_err = 1; end
                OP_ALLOC_MAIN, OP_ALLOC_MINI, OP_MEM:
                    if (cfg_mmu_en && sc_b && !seen[OP_DRAIN]) order_err = 1;
                default: ;
            endcase
            seen = seen | (16'd1 << op_kind);
        end else begin
            op_ack = 1'b0; op_fault = 1'b0; op_hit = 1'b0;
        end
    end

    task automatic sc(input logic [31:0] pa, input logic xf, input logic pf,
                      input logic [2:0] hit, input logic b, input logic c);
        sc_pa = pa; sc_xf = xf; sc_pf = pf; sc_hit = hit; sc_b = b; sc_c = c;
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] ed,
                      input logic [2:0] ef, input logic [15:0] em, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        exp_q.push_back('{ed, ef, em, tag});
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 busy ready low"}, {31'd0, req_ready}, 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk({tag, " R10 done single pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [15:0] TR = 16'h001F;

    initial begin
        repeat (3) @(negedge clk);
        chk("reset ready R10", {31'd0, req_ready}, 32'd1);
        chk("reset done R10",  {31'd0, done}, 32'd0);
        chk("reset op_req R10", {31'd0, op_req}, 32'd0);
        rst_n = 1'b1;

        // R2 translation off
        cfg_mmu_en = 1'b0;
        rd(32'h0000_1003, 2'd0, 32'hA000_1003, 3'd0, 16'h0400, "R2 bypass byte");
        rd(32'h0000_2002, 2'd2, 32'hA000_2002, 3'd0, 16'h0400, "R2 bypass unaligned word");
        // R1 bad size with mmu off
        rd(32'h0000_0000, 2'd3, 32'h0, 3'd4, 16'h0, "R1 bad size mmu off");

        cfg_mmu_en = 1'b1;
        rd(32'h0000_0010, 2'd3, 32'h0, 3'd4, 16'h0, "R1 bad size mmu on");
        // R3
        rd(32'h0000_0102, 2'd2, 32'h0, 3'd1, 16'h0, "R3 misaligned word");
        rd(32'h0000_0101, 2'd1, 32'h0, 3'd1, 16'h0, "R3 misaligned half");
        sc(32'h0004_0000, 0, 0, 3'b000, 0, 0);
        rd(32'h0000_0102, 2'd1, 32'hA004_0002, 3'd0, TR | 16'h0400, "R9 R3 aligned half uncached");
        cfg_align_en = 1'b0;
        sc(32'h0004_0000, 1, 0, 3'b000, 0, 0);
        rd(32'h0000_0103, 2'd2, 32'h0, 3'd2, 16'h0001, "R3 R4 check off xlate fault");
        sc(32'h0004_0000, 0, 1, 3'b000, 0, 0);
        rd(32'h0000_0200, 2'd2, 32'h0, 3'd3, 16'h0003, "R4 perm fault");
        // R5 lookup priority
        sc(32'h0004_0000, 0, 0, 3'b111, 0, 0);
        rd(32'h0000_2007, 2'd0, 32'h2000_2004, 3'd0, 16'h0007, "R5 rb hit");
        sc(32'h0004_0000, 0, 0, 3'b110, 0, 0);
        rd(32'h0000_3008, 2'd2, 32'h3000_3008, 3'd0, 16'h000F, "R5 main hit");
        sc(32'h0004_0000, 0, 0, 3'b100, 0, 0);
        rd(32'h0000_400C, 2'd2, 32'h4000_400C, 3'd0, TR, "R5 mini hit");
        // R6 flush window
        sc(32'hE000_1000, 0, 0, 3'b000, 1, 1);
        rd(32'h0000_5000, 2'd2, 32'h0, 3'd0, TR | 16'h0020, "R6 flush main");
        sc(32'hE000_1000, 0, 0, 3'b000, 0, 1);
        rd(32'h0000_5000, 2'd2, 32'h0, 3'd0, TR | 16'h0040, "R6 flush mini");
        sc(32'hE000_1000, 0, 0, 3'b000, 1, 0);
        rd(32'h0000_5000, 2'd2, 32'h0, 3'd0, TR, "R6 window C0 no action");
        sc(32'hE7FF_FFFC, 0, 0, 3'b000, 0, 1);
        rd(32'h0000_5000, 2'd2, 32'h0, 3'd0, TR | 16'h0040, "R6 window top word");
        sc(32'hE800_0000, 0, 0, 3'b000, 0, 0);
        rd(32'h0000_5003, 2'd0, 32'h4800_0003, 3'd0, TR | 16'h0400, "R6 R9 above window byte");
        sc(32'hDFFF_FFFC, 0, 0, 3'b000, 0, 0);
        rd(32'h0000_5000, 2'd2, 32'h7FFF_FFFC, 3'd0, TR | 16'h0400, "R6 R9 below window word");
        // R7 R8 allocation and drain
        sc(32'h0010_0000, 0, 0, 3'b000, 1, 1);
        rd(32'h0000_6000, 2'd2, 32'h8010_0000, 3'd0, TR | 16'h0180, "R7 R8 drain alloc main");
        sc(32'h0010_0000, 0, 0, 3'b000, 0, 1);
        rd(32'h0000_6000, 2'd2, 32'h9010_0000, 3'd0, TR | 16'h0200, "R8 alloc mini");
        cfg_dcache_en = 1'b0;
        sc(32'h0010_0000, 0, 0, 3'b000, 1, 1);
        rd(32'h0000_6000, 2'd2, 32'hA010_0000, 3'd0, TR | 16'h0480, "R7 R9 drain then memory");
        // R9 halfword merges bit 1 only
        sc(32'h0020_0000, 0, 0, 3'b000, 0, 0);
        rd(32'h0000_6003, 2'd1, 32'hA020_0002, 3'd0, TR | 16'h0400, "R9 half low bits");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule